// File: doc/BRIEF.md
# Raw Uncorrectable Error Recovery Sequencer

This block is the control sequencer that takes over when a load or store finds an unmarked (raw) uncorrectable error in a first-level data cache doubleword. It stalls the access. It then forces a writeback of the whole line to the second-level cache, clean or dirty, and the faulty doubleword is tagged there with the current error-ID value. After that it asks for a refill and replays the access. If the replay still finds a raw error, the loop runs again. A saturating count of recoveries is kept for each way. Once the count for the way reaches a programmable threshold, the sequencer asks the way-reduction logic to disable the way and waits for it to finish. It then converts the raw error into a marked one in place and replays the access one last time.

A load or store that reads a marked doubleword ends in a one-cycle precise trap request. The mark ID reported by the checker is latched into a fault status register at the same time. A doubleword store is the exception: it overwrites the marked doubleword with fresh data and good check bits, so it only gets a one-cycle fix request and no trap. The writeback marking datapath, the arrays and the trap handler all sit outside this block and talk to it through request/done pairs.

Top module: `ue_recovery_seq`

## Requirements
- R1: While and after reset, stall, every request output, dw_fix_req, raw_flag and fsr_marked are low, and the per-way counters are zero.
- R2: An accepted access (acc_valid high in idle) whose chk_status is 2'b01 (raw) raises stall on the next cycle and a writeback request. The request names the access's way and doubleword, and op_mark_id carries err_id_cfg. Stall stays high in every non-idle state.
- R3: Completion of a writeback (wb_done while wb_req) sets the sticky raw_flag.
- R4: Every completed writeback is followed by a refill request, and the access is replayed only after refill_done.
- R5: Each completed writeback increments the way's saturating counter. A replay that still sees raw while the counter is below reduce_thresh starts another writeback.
- R6: A replay that sees raw while the way's counter is at or above reduce_thresh raises reduce_req for that way. After reduce_done, a one-cycle mark_req converts the doubleword in place with err_id_cfg, and the access is replayed.
- R7: A load (acc_kind 2'b00) or store (2'b01) that sees chk_status 2'b10 (marked), either on first access or on a replay, gives one trap_req cycle. On that cycle fsr_marked is high and fsr_mark_id holds chk_mark_id.
- R8: A doubleword store (acc_kind 2'b10) that sees marked data gives a one-cycle dw_fix_req and no trap_req. If this happens on first access, stall is never raised.
- R9: An access that sees clean data (chk_status 2'b00) raises no stall and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_kind | input | 2 | 00 load, 01 store, 10 doubleword store |
| acc_way | input | WAY_W | Way hit by the access |
| acc_dw | input | DW_W | Doubleword index within the line |
| chk_status | input | 2 | Checker verdict: 00 clean, 01 raw, 10 marked |
| chk_mark_id | input | ID_W | Mark ID read from a marked doubleword |
| err_id_cfg | input | ID_W | Current error-ID value used for marking |
| reduce_thresh | input | CNT_W | Recoveries before way reduction |
| wb_done | input | 1 | Writeback finished |
| refill_done | input | 1 | Refill finished |
| reduce_done | input | 1 | Way reduction applied |
| stall | output | 1 | Hold the access |
| tgt_way | output | WAY_W | Way targeted by the current operation |
| tgt_dw | output | DW_W | Doubleword targeted by the current operation |
| op_mark_id | output | ID_W | Mark ID for writeback marking or in-place marking |
| wb_req | output | 1 | Line writeback with marking requested |
| refill_req | output | 1 | Line refill requested |
| reduce_req | output | 1 | Way reduction requested |
| mark_req | output | 1 | Convert raw doubleword to marked in place |
| trap_req | output | 1 | Precise data access error |
| dw_fix_req | output | 1 | Doubleword store overwrites marked data |
| raw_flag | output | 1 | Sticky recoverable raw-error status |
| fsr_marked | output | 1 | Fault status: marked error seen |
| fsr_mark_id | output | ID_W | Fault status: recorded mark ID |

## Verification
The bench builds the block with four ways, eight doublewords per line, an 8-bit mark ID and 2-bit counters. At these sizes a counter saturates at 3, the same as the threshold the bench uses, so both the reduction boundary and the saturation hold are reached after a few raw replays. A second run with a threshold of zero shows that reduction can follow the very first writeback. Counts are carried across accesses to different ways, so one way's history must not leak into another's decision.

// File: rtl/ue_rec_pkg.sv
package ue_rec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITEBACK, ST_REFILL, ST_RETRY, ST_REDUCE, ST_MARK, ST_TRAP
  } rec_state_e;

  localparam logic [1:0] CHK_CLEAN  = 2'b00;
  localparam logic [1:0] CHK_RAW    = 2'b01;
  localparam logic [1:0] CHK_MARKED = 2'b10;

  localparam logic [1:0] ACC_LOAD   = 2'b00;
  localparam logic [1:0] ACC_STORE  = 2'b01;
  localparam logic [1:0] ACC_DSTORE = 2'b10;
endpackage

// File: rtl/ue_way_counters.sv
module ue_way_counters #(
  parameter int WAYS  = 4,
  parameter int CNT_W = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_en,
  input  logic [WAY_W-1:0] inc_way,
  input  logic [WAY_W-1:0] sel_way,
  input  logic [CNT_W-1:0] thresh,
  output logic             at_thresh
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[w] <= '0;
      end else if (inc_en && inc_way == WAY_W'(w) && cnt[w] != CNT_MAX) begin
        cnt[w] <= cnt[w] + 1'b1;
      end
    end
  end

  assign at_thresh = (cnt[sel_way] >= thresh);
endmodule

// File: rtl/ue_rec_fsm.sv
module ue_rec_fsm
  import ue_rec_pkg::*;
#(
  parameter int WAY_W = 2,
  parameter int DW_W  = 3,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [1:0]       acc_kind,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [DW_W-1:0]  acc_dw,
  input  logic [1:0]       chk_status,
  input  logic [ID_W-1:0]  err_id_cfg,
  input  logic             wb_done,
  input  logic             refill_done,
  input  logic             reduce_done,
  input  logic             at_thresh,
  output rec_state_e       state,
  output logic [WAY_W-1:0] tgt_way,
  output logic [DW_W-1:0]  tgt_dw,
  output logic [ID_W-1:0]  op_id,
  output logic             cnt_inc,
  output logic             trap_load,
  output logic             fix_set
);
  rec_state_e nxt;
  logic [1:0] kind_q;
  logic       cap_acc;
  logic       cap_id;

  always_comb begin
    nxt       = state;
    cnt_inc   = 1'b0;
    trap_load = 1'b0;
    fix_set   = 1'b0;
    cap_acc   = 1'b0;
    cap_id    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (acc_valid) begin
          cap_acc = 1'b1;
          if (chk_status == CHK_RAW) begin
            nxt    = ST_WRITEBACK;
            cap_id = 1'b1;
          end else if (chk_status == CHK_MARKED) begin
            if (acc_kind == ACC_DSTORE) begin
              fix_set = 1'b1;
            end else begin
              nxt       = ST_TRAP;
              trap_load = 1'b1;
            end
          end
        end
      end
      ST_WRITEBACK: begin
        if (wb_done) begin
          cnt_inc = 1'b1;
          nxt     = ST_REFILL;
        end
      end
      ST_REFILL: begin
        if (refill_done) nxt = ST_RETRY;
      end
      ST_RETRY: begin
        if (chk_status == CHK_RAW) begin
          if (at_thresh) begin
            nxt = ST_REDUCE;
          end else begin
            nxt    = ST_WRITEBACK;
            cap_id = 1'b1;
          end
        end else if (chk_status == CHK_MARKED) begin
          if (kind_q == ACC_DSTORE) begin
            fix_set = 1'b1;
            nxt     = ST_IDLE;
          end else begin
            trap_load = 1'b1;
            nxt       = ST_TRAP;
          end
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_REDUCE: begin
        if (reduce_done) begin
          nxt    = ST_MARK;
          cap_id = 1'b1;
        end
      end
      ST_MARK: nxt = ST_RETRY;
      ST_TRAP: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tgt_way <= '0;
      tgt_dw  <= '0;
      kind_q  <= ACC_LOAD;
      op_id   <= '0;
    end else begin
      state <= nxt;
      if (cap_acc) begin
        tgt_way <= acc_way;
        tgt_dw  <= acc_dw;
        kind_q  <= acc_kind;
      end
      if (cap_id) op_id <= err_id_cfg;
    end
  end
endmodule

// File: rtl/ue_fault_stat.sv
module ue_fault_stat #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            raw_set,
  input  logic            trap_load,
  input  logic [ID_W-1:0] trap_id,
  input  logic            fix_set,
  output logic            raw_flag,
  output logic            fsr_marked,
  output logic [ID_W-1:0] fsr_mark_id,
  output logic            dw_fix_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_flag    <= 1'b0;
      fsr_marked  <= 1'b0;
      fsr_mark_id <= '0;
      dw_fix_req  <= 1'b0;
    end else begin
      if (raw_set) raw_flag <= 1'b1;
      if (trap_load) begin
        fsr_marked  <= 1'b1;
        fsr_mark_id <= trap_id;
      end
      dw_fix_req <= fix_set;
    end
  end
endmodule

// File: rtl/ue_recovery_seq.sv
module ue_recovery_seq
  import ue_rec_pkg::*;
#(
  parameter int WAYS    = 4,
  parameter int LINE_DW = 8,
  parameter int ID_W    = 8,
  parameter int CNT_W   = 2,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int DW_W   = (LINE_DW > 1) ? $clog2(LINE_DW) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [1:0]       acc_kind,
  input  logic [WAY_W-1:0] acc_way,
  input  logic [DW_W-1:0]  acc_dw,
  input  logic [1:0]       chk_status,
  input  logic [ID_W-1:0]  chk_mark_id,
  input  logic [ID_W-1:0]  err_id_cfg,
  input  logic [CNT_W-1:0] reduce_thresh,
  input  logic             wb_done,
  input  logic             refill_done,
  input  logic             reduce_done,
  output logic             stall,
  output logic [WAY_W-1:0] tgt_way,
  output logic [DW_W-1:0]  tgt_dw,
  output logic [ID_W-1:0]  op_mark_id,
  output logic             wb_req,
  output logic             refill_req,
  output logic             reduce_req,
  output logic             mark_req,
  output logic             trap_req,
  output logic             dw_fix_req,
  output logic             raw_flag,
  output logic             fsr_marked,
  output logic [ID_W-1:0]  fsr_mark_id
);
  rec_state_e state;
  logic       at_thresh;
  logic       cnt_inc;
  logic       trap_load;
  logic       fix_set;

  ue_rec_fsm #(.WAY_W(WAY_W), .DW_W(DW_W), .ID_W(ID_W)) u_fsm (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_way(acc_way), .acc_dw(acc_dw),
    .chk_status(chk_status), .err_id_cfg(err_id_cfg),
    .wb_done(wb_done), .refill_done(refill_done), .reduce_done(reduce_done),
    .at_thresh(at_thresh), .state(state), .tgt_way(tgt_way), .tgt_dw(tgt_dw),
    .op_id(op_mark_id), .cnt_inc(cnt_inc), .trap_load(trap_load), .fix_set(fix_set)
  );

  ue_way_counters #(.WAYS(WAYS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc_en(cnt_inc), .inc_way(tgt_way),
    .sel_way(tgt_way), .thresh(reduce_thresh), .at_thresh(at_thresh)
  );

  ue_fault_stat #(.ID_W(ID_W)) u_stat (
    .clk(clk), .rst(rst), .raw_set(cnt_inc), .trap_load(trap_load),
    .trap_id(chk_mark_id), .fix_set(fix_set), .raw_flag(raw_flag),
    .fsr_marked(fsr_marked), .fsr_mark_id(fsr_mark_id), .dw_fix_req(dw_fix_req)
  );

  assign stall      = (state != ST_IDLE);
  assign wb_req     = (state == ST_WRITEBACK);
  assign refill_req = (state == ST_REFILL);
  assign reduce_req = (state == ST_REDUCE);
  assign mark_req   = (state == ST_MARK);
  assign trap_req   = (state == ST_TRAP);
endmodule

// File: rtl/ue_recovery_seq_chk.sv
module ue_recovery_seq_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic            wb_req,
  input logic            wb_done,
  input logic            refill_req,
  input logic            reduce_req,
  input logic            reduce_done,
  input logic            mark_req,
  input logic            trap_req,
  input logic            dw_fix_req,
  input logic            raw_flag,
  input logic            fsr_marked,
  input logic [ID_W-1:0] op_mark_id
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!stall && !trap_req && !raw_flag && !fsr_marked && !dw_fix_req));

  p_one_req_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wb_req, refill_req, reduce_req, mark_req, trap_req}));

  p_stall_held_r2: assert property (@(posedge clk) disable iff (rst)
    (wb_req || refill_req || reduce_req || mark_req || trap_req) |-> stall);

  p_wb_id_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_done) |=> $stable(op_mark_id));

  p_raw_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (wb_req && wb_done) |=> raw_flag);

  p_refill_next_r4: assert property (@(posedge clk) disable iff (rst)
    (wb_req && wb_done) |=> refill_req);

  p_mark_after_reduce_r6: assert property (@(posedge clk) disable iff (rst)
    (reduce_req && reduce_done) |=> mark_req);

  p_trap_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    trap_req |=> !trap_req);

  p_fsr_on_trap_r7: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> fsr_marked);

  p_fix_no_trap_r8: assert property (@(posedge clk) disable iff (rst)
    dw_fix_req |-> !trap_req);
endmodule

bind ue_recovery_seq ue_recovery_seq_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .wb_req(wb_req), .wb_done(wb_done),
  .refill_req(refill_req), .reduce_req(reduce_req), .reduce_done(reduce_done),
  .mark_req(mark_req), .trap_req(trap_req), .dw_fix_req(dw_fix_req),
  .raw_flag(raw_flag), .fsr_marked(fsr_marked), .op_mark_id(op_mark_id)
);

// File: tb/ue_recovery_seq_tb.sv
module ue_recovery_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 4, LINE_DW = 8, ID_W = 8, CNT_W = 2;
  localparam logic [7:0] ERR_ID = 8'h2A;
  localparam logic [1:0] CK_CLEAN = 2'b00, CK_RAW = 2'b01, CK_MARK = 2'b10;
  localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_DST = 2'b10;

  typedef struct packed {
    logic [1:0] kind; logic [1:0] way; logic [2:0] dw; logic [3:0] nraw;
    logic [1:0] fin;  logic [7:0] fid;
    logic [3:0] ewb;  logic [1:0] ered; logic etrap; logic efix; logic [7:0] eid;
  } vec_t;

  // threshold 3; counts carry across rows
  localparam vec_t VECS [9] = '{
    '{K_LD,  2'd0, 3'd1, 4'd0, CK_CLEAN, 8'h00, 4'd0, 2'd0, 1'b0, 1'b0, 8'h00},
    '{K_LD,  2'd0, 3'd2, 4'd0, CK_MARK,  8'h05, 4'd0, 2'd0, 1'b1, 1'b0, 8'h05},
    '{K_DST, 2'd1, 3'd0, 4'd0, CK_MARK,  8'h06, 4'd0, 2'd0, 1'b0, 1'b1, 8'h00},
    '{K_ST,  2'd1, 3'd3, 4'd1, CK_CLEAN, 8'h00, 4'd1, 2'd0, 1'b0, 1'b0, 8'h00},
    '{K_LD,  2'd2, 3'd4, 4'd2, CK_CLEAN, 8'h00, 4'd2, 2'd0, 1'b0, 1'b0, 8'h00},
    '{K_LD,  2'd3, 3'd5, 4'd5, CK_CLEAN, 8'h00, 4'd3, 2'd1, 1'b1, 1'b0, ERR_ID},
    '{K_LD,  2'd2, 3'd4, 4'd2, CK_CLEAN, 8'h00, 4'd1, 2'd1, 1'b1, 1'b0, ERR_ID},
    '{K_DST, 2'd3, 3'd1, 4'd1, CK_MARK,  8'h07, 4'd1, 2'd0, 1'b0, 1'b1, 8'h00},
    '{K_ST,  2'd0, 3'd7, 4'd3, CK_CLEAN, 8'h00, 4'd3, 2'd0, 1'b0, 1'b0, 8'h00}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [1:0] acc_kind = '0;
  logic [1:0] acc_way = '0;
  logic [2:0] acc_dw = '0;
  logic [1:0] chk_status = '0;
  logic [7:0] chk_mark_id = '0;
  logic [7:0] err_id_cfg = ERR_ID;
  logic [1:0] reduce_thresh = 2'd3;
  logic wb_done = 1'b0, refill_done = 1'b0, reduce_done = 1'b0;
  logic stall, wb_req, refill_req, reduce_req, mark_req, trap_req, dw_fix_req;
  logic raw_flag, fsr_marked;
  logic [1:0] tgt_way;
  logic [2:0] tgt_dw;
  logic [7:0] op_mark_id, fsr_mark_id;

  int n_checks = 0, n_errors = 0, cycles = 0;
  int o_wb, o_red, o_mark, o_trap, o_fix, o_bad;
  bit o_stall, any_wb = 0;

  ue_recovery_seq #(.WAYS(WAYS), .LINE_DW(LINE_DW), .ID_W(ID_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_way(acc_way),
    .acc_dw(acc_dw), .chk_status(chk_status), .chk_mark_id(chk_mark_id),
    .err_id_cfg(err_id_cfg), .reduce_thresh(reduce_thresh), .wb_done(wb_done),
    .refill_done(refill_done), .reduce_done(reduce_done), .stall(stall),
    .tgt_way(tgt_way), .tgt_dw(tgt_dw), .op_mark_id(op_mark_id), .wb_req(wb_req),
    .refill_req(refill_req), .reduce_req(reduce_req), .mark_req(mark_req),
    .trap_req(trap_req), .dw_fix_req(dw_fix_req), .raw_flag(raw_flag),
    .fsr_marked(fsr_marked), .fsr_mark_id(fsr_mark_id)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_errors = n_errors + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_acc(input logic [1:0] k, input logic [1:0] w, input logic [2:0] d,
                         input int nraw, input logic [1:0] fin, input logic [7:0] fid);
    int used;
    o_wb = 0; o_red = 0; o_mark = 0; o_trap = 0; o_fix = 0; o_bad = 0; o_stall = 0;
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_way = w; acc_dw = d;
    if (nraw > 0) begin chk_status = CK_RAW; used = 1; end
    else begin chk_status = fin; chk_mark_id = fid; used = 0; end
    @(negedge clk);
    acc_valid = 1'b0;
    for (int i = 0; i < 80; i++) begin
      wb_done = wb_req; refill_done = refill_req; reduce_done = reduce_req;
      if (stall) o_stall = 1;
      if (wb_req) begin
        o_wb++;
        if (op_mark_id != ERR_ID || tgt_way != w || tgt_dw != d) o_bad++;
      end
      if (refill_req) begin
        if (used < nraw) begin chk_status = CK_RAW; used++; end
        else begin chk_status = fin; chk_mark_id = fid; end
      end
      if (reduce_req) begin o_red++; if (tgt_way != w) o_bad++; end
      if (mark_req) begin
        o_mark++;
        if (op_mark_id != ERR_ID || tgt_dw != d) o_bad++;
        chk_status = CK_MARK; chk_mark_id = ERR_ID;
      end
      if (trap_req) o_trap++;
      if (dw_fix_req) o_fix++;
      if (!stall) break;
      @(negedge clk);
    end
    wb_done = 0; refill_done = 0; reduce_done = 0; chk_status = CK_CLEAN;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 stall after reset", stall, 0);
    chk("R1 requests after reset", {wb_req, refill_req, reduce_req, mark_req, trap_req, dw_fix_req}, 0);
    chk("R1 flags after reset", {raw_flag, fsr_marked}, 0);
    rst = 1'b0;

    foreach (VECS[n]) begin
      run_acc(VECS[n].kind, VECS[n].way, VECS[n].dw, int'(VECS[n].nraw), VECS[n].fin, VECS[n].fid);
      if (VECS[n].ewb != 0) any_wb = 1;
      chk($sformatf("R2/R5 writebacks row %0d", n), o_wb, int'(VECS[n].ewb));
      chk($sformatf("R2 writeback target/id row %0d", n), o_bad, 0);
      chk($sformatf("R6 reductions row %0d", n), o_red, int'(VECS[n].ered));
      chk($sformatf("R6 in-place marks row %0d", n), o_mark, int'(VECS[n].ered));
      chk($sformatf("R7 traps row %0d", n), o_trap, int'(VECS[n].etrap));
      chk($sformatf("R8 fixes row %0d", n), o_fix, int'(VECS[n].efix));
      chk($sformatf("R3 raw flag row %0d", n), raw_flag, int'(any_wb));
      if (VECS[n].ewb != 0) chk($sformatf("R2 stall during recovery row %0d", n), o_stall, 1);
      if (VECS[n].etrap) chk($sformatf("R7 fsr id row %0d", n), fsr_mark_id, int'(VECS[n].eid));
      if (VECS[n].ewb == 0 && !VECS[n].etrap)
        chk($sformatf("R8/R9 no stall row %0d", n), o_stall, 0);
      // R4 is implied by progress: the bench only releases replays after refill
    end

    // Directed: reset clears flags and counters, then threshold 0
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 flags cleared by reset", {raw_flag, fsr_marked}, 0);
    rst = 1'b0; reduce_thresh = 2'd0;
    run_acc(K_LD, 2'd1, 3'd6, 2, CK_CLEAN, 8'h00);
    chk("R6 thr0 writebacks", o_wb, 1);
    chk("R6 thr0 reduction", o_red, 1);
    chk("R7 thr0 trap", o_trap, 1);
    chk("R7 thr0 fsr id", fsr_mark_id, int'(ERR_ID));

    // Directed: R4 refill must wait for refill_done
    reduce_thresh = 2'd3;
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = K_ST; acc_way = 2'd2; acc_dw = 3'd3; chk_status = CK_RAW;
    @(negedge clk); acc_valid = 1'b0; wb_done = 1'b1;
    @(negedge clk); wb_done = 1'b0; chk_status = CK_CLEAN;
    chk("R4 refill after writeback", refill_req, 1);
    repeat (3) @(negedge clk);
    chk("R4 refill held without done", refill_req, 1);
    refill_done = 1'b1;
    @(negedge clk); refill_done = 1'b0;
    @(negedge clk);
    chk("R4 idle after clean replay", stall, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule